// File: doc/BRIEF.md
# Fall-through bubble FIFO

This block is a first-in-first-out buffer built as a chain of word stages. It uses no RAM and no read or write pointers. Each stage holds one data word and a single occupancy marker. On every clock edge, a stage that is vacant takes the word from an occupied stage just before it. Written words therefore fall through toward the output end on their own, and vacancies bubble back toward the input end. Word order is preserved the whole way.

The write side has a shift-in strobe, a data word and an input-ready flag. Input-ready is high exactly when the first stage is vacant. The read side has a shift-out strobe, the word in the last stage, and an output-ready flag that is high whenever the last stage holds a word. The data outputs are released to high impedance when the output enable is low. An asynchronous master reset empties the chain. Both edges use a ready/strobe handshake, so two buffers can be chained for more depth: the upstream output-ready drives the downstream shift-in, and the downstream input-ready drives the upstream shift-out. Buffers can also be placed side by side for more width.

Everything is synchronous to one clock. Every stage applies its move rule at the same time, using the markers from the previous cycle, so no combinational path runs along the chain.

Top module: `bubble_fifo`

## Requirements
- R1: While `mrst` (active high, asynchronous) is 1, and after it is released, every marker is clear: `in_rdy` is 1 and `out_rdy` is 0.
- R2: A clock edge with `shin`=1 and `in_rdy`=1 captures `din` into the first stage, so `in_rdy` is 0 after that edge. With the second stage vacant, `in_rdy` returns to 1 one edge later.
- R3: A `shin` pulse while `in_rdy`=0 is ignored. No word is added, and only the accepted words are ever read out.
- R4: Suppose a word is captured into an empty buffer of DEPTH stages at edge E. Then `out_rdy` stays 0 through edge E+DEPTH-2 and is 1 after edge E+DEPTH-1, showing that word on `dout`.
- R5: Words leave in exactly the order they were accepted, for any interleaving of writes and reads.
- R6: The buffer holds exactly DEPTH words. After DEPTH accepted writes with no reads, once the words settle, `in_rdy` is 0 and `out_rdy` is 1.
- R7: An edge with `shout`=1 and `out_rdy`=1 removes the last word, so `out_rdy` is 0 after that edge (no same-cycle refill). `shout` while `out_rdy`=0 has no effect.
- R8: With `oe`=1, `dout` drives the last stage's word. With `oe`=0, `dout` is high impedance.
- R9: Asserting `mrst` while words are stored discards them all. Afterwards the buffer accepts and delivers new words normally.
- R10: Two instances chained (upstream `out_rdy` to downstream `shin`, upstream `dout` to downstream `din`, downstream `in_rdy` to upstream `shout`) act as one buffer of 2*DEPTH words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, asynchronous, active high; clears all markers |
| shin | input | 1 | Shift-in strobe |
| din | input | WIDTH | Word to write |
| in_rdy | output | 1 | First stage vacant (write possible) |
| shout | input | 1 | Shift-out strobe |
| out_rdy | output | 1 | Last stage holds a word |
| oe | input | 1 | Output enable for `dout`, active high |
| dout | output | WIDTH | Word in the last stage, or high impedance when `oe`=0 |

## Verification
The checker keeps its own count of accepted writes minus accepted reads. It assumes that the strobes are sampled only on clock edges and that a strobe seen against a low ready flag is meaningful only as a no-op. Under that assumption, it compares the count with the number of occupied stages. The bench drives `shin`, `shout`, `din` and `oe` only at falling edges. It deliberately holds `shin` high against a full buffer and `shout` high against an empty one, so both no-op cases are exercised inside those assumptions. Chained instances are driven only through their handshakes, which keeps each instance's strobes consistent with its own ready flags.

// File: rtl/bubble_fifo_pkg.sv
package bubble_fifo_pkg;

   // Smallest chain the stage wiring supports.
   localparam int unsigned BF_MIN_DEPTH = 1;
   localparam int unsigned BF_MIN_WIDTH = 1;

   // Bits needed to count 0..depth occupied stages, with one spare bit
   // so an over-count would be visible instead of wrapping.
   function automatic int unsigned bf_occ_width(input int unsigned depth);
      return $clog2(depth + 1) + 1;
   endfunction

endpackage

// File: rtl/bf_stage.sv
// One word position of the chain: an occupancy marker plus a data latch.
// The stage loads when it is vacant and the upstream side offers a word.
// It empties when it is occupied and the downstream side takes its word.
module bf_stage #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             up_valid,   // upstream offers a word
   input  logic [WIDTH-1:0] up_data,
   input  logic             down_take,  // downstream will take our word
   output logic             mark_o,
   output logic [WIDTH-1:0] data_o
);

   logic             mark_q;
   logic [WIDTH-1:0] data_q;
   logic             arrive;
   logic             depart;

   // Both terms use only last cycle's markers, so there is no ripple.
   assign arrive = ~mark_q & up_valid;
   assign depart = mark_q & down_take;

   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         mark_q <= 1'b0;
      end else if (arrive) begin
         mark_q <= 1'b1;
      end else if (depart) begin
         mark_q <= 1'b0;
      end
   end

   // The data latch needs no reset; a cleared marker makes its contents void.
   always_ff @(posedge clk) begin
      if (arrive) begin
         data_q <= up_data;
      end
   end

   assign mark_o = mark_q;
   assign data_o = data_q;

endmodule

// File: rtl/bf_outdrv.sv
// Three-state driver for the read-side data word.
module bf_outdrv #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   assign q = en ? d : {WIDTH{1'bz}};

endmodule

// File: rtl/bubble_fifo.sv
// Fall-through FIFO built as a chain of marker-qualified word stages.
// Stage 0 sits at the input end; stage DEPTH-1 sits at the output end.
module bubble_fifo
   import bubble_fifo_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             shin,
   input  logic [WIDTH-1:0] din,
   output logic             in_rdy,
   input  logic             shout,
   output logic             out_rdy,
   input  logic             oe,
   output logic [WIDTH-1:0] dout
);

   localparam int unsigned LAST = DEPTH - 1;

   // Elaboration-time parameter checks.
   if (DEPTH < BF_MIN_DEPTH) begin : g_bad_depth
      $error("bubble_fifo: DEPTH must be at least %0d", BF_MIN_DEPTH);
   end
   if (WIDTH < BF_MIN_WIDTH) begin : g_bad_width
      $error("bubble_fifo: WIDTH must be at least %0d", BF_MIN_WIDTH);
   end

   logic [DEPTH-1:0] mark;
   logic [WIDTH-1:0] word [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic             up_v;
      logic [WIDTH-1:0] up_d;
      logic             dn_t;

      // Upstream side: the write port for the head stage, the previous
      // stage otherwise.
      if (i == 0) begin : g_head
         assign up_v = shin;
         assign up_d = din;
      end else begin : g_link_up
         assign up_v = mark[i-1];
         assign up_d = word[i-1];
      end

      // Downstream side: the read strobe for the tail stage, a vacancy in
      // the next stage otherwise.
      if (i == LAST) begin : g_tail
         assign dn_t = shout;
      end else begin : g_link_dn
         assign dn_t = ~mark[i+1];
      end

      bf_stage #(.WIDTH(WIDTH)) u_stage (
         .clk      (clk),
         .mrst     (mrst),
         .up_valid (up_v),
         .up_data  (up_d),
         .down_take(dn_t),
         .mark_o   (mark[i]),
         .data_o   (word[i])
      );
   end

   // The ready flags come straight from the end-stage marker flops.
   assign in_rdy  = ~mark[0];
   assign out_rdy = mark[LAST];

   bf_outdrv #(.WIDTH(WIDTH)) u_outdrv (
      .en(oe),
      .d (word[LAST]),
      .q (dout)
   );

endmodule

// File: rtl/bubble_fifo_chk.sv
// Checker bound to every bubble_fifo instance.
module bubble_fifo_chk
   import bubble_fifo_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned DEPTH = 16
) (
   input logic             clk,
   input logic             mrst,
   input logic             shin,
   input logic             shout,
   input logic             in_rdy,
   input logic             out_rdy,
   input logic [DEPTH-1:0] mark,
   input logic [WIDTH-1:0] dout
);

   localparam int unsigned CW = bf_occ_width(DEPTH);

   // Occupancy computed from the handshakes only.
   logic [CW-1:0] occ;
   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         occ <= '0;
      end else begin
         occ <= occ + CW'(shin & in_rdy) - CW'(shout & out_rdy);
      end
   end

   // R6: the stages hold exactly the words accepted minus the words removed.
   assert_occupancy_R6: assert property (@(posedge clk) disable iff (mrst)
      $countones(mark) == int'(occ));

   // R6: never more than DEPTH words.
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (mrst)
      int'(occ) <= int'(DEPTH));

   // R2: an accepted write occupies the head stage.
   assert_accept_R2: assert property (@(posedge clk) disable iff (mrst)
      (shin && in_rdy) |=> !in_rdy);

   // R3: a refused write leaves the stored word count unchanged unless a read happens.
   assert_refuse_R3: assert property (@(posedge clk) disable iff (mrst)
      (shin && !in_rdy && !(shout && out_rdy)) |=>
         $countones(mark) == $past($countones(mark)));

   // R7: a read empties the tail for at least one cycle.
   assert_drain_R7: assert property (@(posedge clk) disable iff (mrst)
      (shout && out_rdy) |=> !out_rdy);

   // R4: a word at the tail stays until it is read.
   assert_hold_R4: assert property (@(posedge clk) disable iff (mrst)
      (out_rdy && !shout) |=> (out_rdy && $stable(dout)));

   // R1: an empty chain offers no word.
   assert_empty_R1: assert property (@(posedge clk) disable iff (mrst)
      (occ == '0) |-> (!out_rdy && in_rdy));

endmodule

bind bubble_fifo bubble_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
   .clk    (clk),
   .mrst   (mrst),
   .shin   (shin),
   .shout  (shout),
   .in_rdy (in_rdy),
   .out_rdy(out_rdy),
   .mark   (mark),
   .dout   (word[DEPTH-1])
);

// File: tb/tb_bubble_fifo.sv
module tb_bubble_fifo;

   localparam int W = 4;
   localparam int D = 16;

   logic         clk = 1'b0;
   logic         mrst = 1'b1;
   logic         shin = 1'b0;
   logic [W-1:0] din = '0;
   logic         shout = 1'b0;
   logic         oe = 1'b1;
   wire          in_rdy;
   wire          out_rdy;
   wire  [W-1:0] dout;

   // Chained pair for R10.
   logic         ca_shin = 1'b0;
   logic [W-1:0] ca_din = '0;
   logic         cb_shout = 1'b0;
   wire          ca_in_rdy, ca_out_rdy, cb_in_rdy, cb_out_rdy;
   wire  [W-1:0] ca_dout, cb_dout;

   int checks = 0;
   int fails  = 0;
   logic [W-1:0] model[$];

   always #5 clk = ~clk;

   bubble_fifo #(.WIDTH(W), .DEPTH(D)) dut (
      .clk(clk), .mrst(mrst), .shin(shin), .din(din), .in_rdy(in_rdy),
      .shout(shout), .out_rdy(out_rdy), .oe(oe), .dout(dout));

   bubble_fifo #(.WIDTH(W), .DEPTH(D)) ca (
      .clk(clk), .mrst(mrst), .shin(ca_shin), .din(ca_din), .in_rdy(ca_in_rdy),
      .shout(cb_in_rdy), .out_rdy(ca_out_rdy), .oe(1'b1), .dout(ca_dout));

   bubble_fifo #(.WIDTH(W), .DEPTH(D)) cb (
      .clk(clk), .mrst(mrst), .shin(ca_out_rdy), .din(ca_dout), .in_rdy(cb_in_rdy),
      .shout(cb_shout), .out_rdy(cb_out_rdy), .oe(1'b1), .dout(cb_dout));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      mrst = 1'b1; shin = 1'b0; shout = 1'b0; ca_shin = 1'b0; cb_shout = 1'b0;
      model.delete();
      @(negedge clk);
      mrst = 1'b0;
   endtask

   // Write one word, waiting for in_rdy; starts and ends at a falling edge.
   task automatic push(input logic [W-1:0] w);
      int n = 0;
      while (!in_rdy && n < 8 * D) begin @(negedge clk); n++; end
      chk(in_rdy == 1'b1, "R2 wait in_rdy", in_rdy, 1);
      shin = 1'b1; din = w; model.push_back(w);
      @(negedge clk);
      shin = 1'b0;
      chk(in_rdy == 1'b0, "R2 head filled", in_rdy, 0);
   endtask

   // Read one word, comparing against the model.
   task automatic pop();
      int n = 0;
      logic [W-1:0] e;
      while (!out_rdy && n < 8 * D) begin @(negedge clk); n++; end
      chk(out_rdy == 1'b1, "R5 wait out_rdy", out_rdy, 1);
      e = (model.size() > 0) ? model.pop_front() : 'x;
      chk(dout == e, "R5 order", dout, e);
      shout = 1'b1;
      @(negedge clk);
      shout = 1'b0;
      chk(out_rdy == 1'b0, "R7 tail cleared", out_rdy, 0);
   endtask

   task automatic t_reset();
      #1;
      chk(in_rdy == 1'b1 && out_rdy == 1'b0, "R1 during reset", {in_rdy, out_rdy}, 2'b10);
      do_reset();
      @(negedge clk);
      chk(in_rdy == 1'b1 && out_rdy == 1'b0, "R1 after reset", {in_rdy, out_rdy}, 2'b10);
   endtask

   task automatic t_fall_through();
      do_reset();
      shin = 1'b1; din = 4'hA;
      for (int k = 1; k <= D; k++) begin
         @(negedge clk);
         if (k == 1) begin
            shin = 1'b0;
            chk(in_rdy == 1'b0, "R2 captured", in_rdy, 0);
         end
         if (k == 2) chk(in_rdy == 1'b1, "R2 head vacated", in_rdy, 1);
         if (k < D) begin
            if (out_rdy !== 1'b0) chk(1'b0, "R4 early out_rdy", k, D);
         end else begin
            chk(out_rdy == 1'b1, "R4 arrival edge", out_rdy, 1);
            chk(dout == 4'hA, "R4 word", dout, 4'hA);
         end
      end
      model.push_back(4'hA);
      pop();
   endtask

   task automatic t_empty_shout();
      do_reset();
      shout = 1'b1;
      repeat (4) @(negedge clk);
      shout = 1'b0;
      push(4'h3);
      pop();
      chk(model.size() == 0, "R7 shout when empty ignored", model.size(), 0);
   endtask

   task automatic t_order();
      do_reset();
      for (int i = 0; i < 5; i++) push(W'(i * 3 + 1));
      repeat (2) pop();
      for (int i = 0; i < 7; i++) push(W'(15 - i));
      push(4'h0); pop(); push(4'hF);
      while (model.size() > 0) pop();
      chk(1'b1, "R5 interleaved done", 0, 0);
   endtask

   task automatic t_fill_ignore();
      do_reset();
      for (int i = 0; i < D; i++) push(W'(i ^ 5));
      repeat (2 * D) @(negedge clk);
      chk(in_rdy == 1'b0, "R6 full in_rdy", in_rdy, 0);
      chk(out_rdy == 1'b1, "R6 full out_rdy", out_rdy, 1);
      shin = 1'b1; din = 4'hE;
      repeat (3) @(negedge clk);
      shin = 1'b0;
      chk(in_rdy == 1'b0, "R3 still full", in_rdy, 0);
      for (int i = 0; i < D; i++) pop();
      repeat (2 * D) @(negedge clk);
      chk(out_rdy == 1'b0, "R3 no extra word", out_rdy, 0);
      chk(in_rdy == 1'b1, "R6 drained", in_rdy, 1);
   endtask

   task automatic t_oe();
      do_reset();
      push(4'h5);
      repeat (D + 1) @(negedge clk);
      oe = 1'b0; #1;
      chk(dout !== 4'h5, "R8 released", dout, 4'hz);
      @(negedge clk);
      oe = 1'b1; #1;
      chk(dout === 4'h5, "R8 driven", dout, 4'h5);
      pop();
   endtask

   task automatic t_midreset();
      do_reset();
      push(4'h1); push(4'h2); push(4'h4);
      repeat (3) @(negedge clk);
      mrst = 1'b1; #1;
      chk(in_rdy == 1'b1 && out_rdy == 1'b0, "R9 async clear", {in_rdy, out_rdy}, 2'b10);
      @(negedge clk);
      mrst = 1'b0; model.delete();
      repeat (2 * D) @(negedge clk);
      chk(out_rdy == 1'b0, "R9 words discarded", out_rdy, 0);
      push(4'h9);
      pop();
   endtask

   task automatic t_cascade();
      logic [W-1:0] q[$];
      int n;
      do_reset();
      for (int i = 0; i < 2 * D; i++) begin
         n = 0;
         while (!ca_in_rdy && n < 16 * D) begin @(negedge clk); n++; end
         ca_shin = 1'b1; ca_din = W'(i * 7 + 2); q.push_back(W'(i * 7 + 2));
         @(negedge clk);
         ca_shin = 1'b0;
      end
      repeat (4 * D) @(negedge clk);
      chk(ca_in_rdy == 1'b0, "R10 pair full", ca_in_rdy, 0);
      chk(cb_out_rdy == 1'b1, "R10 pair out_rdy", cb_out_rdy, 1);
      for (int i = 0; i < 2 * D; i++) begin
         logic [W-1:0] e;
         n = 0;
         while (!cb_out_rdy && n < 16 * D) begin @(negedge clk); n++; end
         e = q.pop_front();
         if (cb_dout !== e) chk(1'b0, "R10 order", cb_dout, e);
         cb_shout = 1'b1;
         @(negedge clk);
         cb_shout = 1'b0;
      end
      chk(1'b1, "R10 order done", 0, 0);
      repeat (4 * D) @(negedge clk);
      chk(cb_out_rdy == 1'b0, "R10 pair empty", cb_out_rdy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_fall_through();
      t_empty_shout();
      t_order();
      t_fill_ignore();
      t_oe();
      t_midreset();
      t_cascade();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule